// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a very small accumulator-style computer. It holds the machine phase and steps each instruction through a fetch phase, a decode phase and one execute phase chosen by the opcode, then starts the next fetch. In every phase it drives the control lines of a datapath built from a program counter, an instruction register, a register file, a memory port, an ALU and a flag register. The datapath itself sits outside the block.

The instruction word is 16 bits wide. Bits [15:14] hold the opcode. Bits [13:7] hold the destination operand and bits [6:0] hold the source operand. Both operands share one 7-bit address space. When the top bit of an operand (bit 6 of the field) is 0 it names a register, so AX is 0000001. When that bit is 1 it names a memory word. The block supports four opcodes: a no-operation, a move, an add, and a jump that is taken when the last ALU result was negative or zero. The jump decision uses the sign and zero flags that the datapath holds.

The block reads the instruction register contents and those two flags. It returns the phase, the operand addresses and their register-or-memory kind, the write strobes, the ALU operation and the program-counter controls.

Top module: `mc_sequencer`

## Requirements
- R1: While rst_n is low, the phase is Fetch (code 0) and rf_we, mem_we, flag_we and pc_load are all 0. Reset acts at once, without waiting for a clock edge.
- R2: In Fetch, ir_load, pc_inc and addr_pc_sel are 1 and every other strobe is 0. The next phase is Decode (code 1).
- R3: In Decode, every strobe is 0. The opcode in bits [15:14] selects the next phase: 01 gives Move (code 2), 11 gives Add (code 3), 10 gives Jump (code 4) and 00 gives Fetch.
- R4: Each execute phase (Move, Add or Jump) is followed by Fetch. A Move, Add or Jump therefore takes three cycles.
- R5: dst_addr equals bits [13:7] and src_addr equals bits [6:0]. dst_is_mem and src_is_mem equal bit 6 of their own field (1 means memory, 0 means register). pc_target equals the source field.
- R6: In Move, exactly one of mem_we (destination is memory) and rf_we (destination is a register) is 1. alu_op is 0 (pass the source through) and flag_we is 0.
- R7: In Add, alu_op is 1 (destination plus source). The destination write strobe follows the rule of R6. flag_we is 1 in the same cycle as that write.
- R8: In Jump, pc_load equals flag_sign OR flag_zero. rf_we, mem_we and flag_we are 0.
- R9: A no-operation (opcode 00) raises no write strobe in any of its two cycles, Fetch and Decode, and then returns to Fetch.
- R10: rf_we and mem_we are never 1 together. pc_inc and pc_load are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ir_word | input | 16 | Current instruction register contents |
| flag_zero | input | 1 | Zero flag held by the datapath |
| flag_sign | input | 1 | Sign flag held by the datapath |
| phase | output | 3 | Current phase: 0 Fetch, 1 Decode, 2 Move, 3 Add, 4 Jump |
| ir_load | output | 1 | Load the instruction register from memory |
| pc_inc | output | 1 | Increment the program counter |
| pc_load | output | 1 | Load the program counter from pc_target |
| pc_target | output | 7 | Jump target address |
| addr_pc_sel | output | 1 | Memory port is addressed by the program counter |
| dst_addr | output | 7 | Destination operand address |
| src_addr | output | 7 | Source operand address |
| dst_is_mem | output | 1 | Destination is a memory word |
| src_is_mem | output | 1 | Source is a memory word |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Memory write enable |
| alu_op | output | 1 | ALU operation: 0 pass source, 1 add |
| flag_we | output | 1 | Flag register write enable |

## Verification
In an Add, the write of the destination and the update of the flags happen in the same execute cycle. If either strobe were moved to another cycle, the flags would not match the stored sum. The bench provokes this case with Add instructions whose destination is a register and with Add instructions whose destination is memory. In the one Add cycle it samples both strobes, the ALU operation and the kind of destination together, and compares them with values worked out from the requirements. The sweep covers every opcode, every register-or-memory kind of both operands and every sign and zero flag combination.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W = 2;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_MOV    = 3'd2,
    PH_ADD    = 3'd3,
    PH_JNG    = 3'd4
  } phase_e;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP = 2'b00,
    OPC_MOV = 2'b01,
    OPC_JNG = 2'b10,
    OPC_ADD = 2'b11
  } opc_e;

  typedef struct packed {
    logic ir_load;
    logic pc_inc;
    logic pc_load;
    logic addr_pc_sel;
    logic rf_we;
    logic mem_we;
    logic alu_add;
    logic flag_we;
  } ctrl_t;
endpackage

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e nxt_i,
  output phase_e cur_o
);
  phase_e cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= PH_FETCH;
    else        cur_q <= nxt_i;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
  import seq_pkg::*;
(
  input  phase_e cur_i,
  input  opc_e   opcode_i,
  output phase_e nxt_o
);
  always_comb begin
    nxt_o = PH_FETCH;
    case (cur_i)
      PH_FETCH:  nxt_o = PH_DECODE;
      PH_DECODE: begin
        case (opcode_i)
          OPC_MOV: nxt_o = PH_MOV;
          OPC_ADD: nxt_o = PH_ADD;
          OPC_JNG: nxt_o = PH_JNG;
          default: nxt_o = PH_FETCH;
        endcase
      end
      default:   nxt_o = PH_FETCH;
    endcase
  end
endmodule

// File: rtl/seq_operand_split.sv
module seq_operand_split #(
  parameter int ADDR_W = 7,
  parameter int N_OPND = 2
) (
  input  logic [N_OPND*ADDR_W-1:0] field_i,
  output logic [N_OPND*ADDR_W-1:0] addr_o,
  output logic [N_OPND-1:0]        is_mem_o
);
  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    assign addr_o[g*ADDR_W +: ADDR_W] = field_i[g*ADDR_W +: ADDR_W];
    assign is_mem_o[g]                = field_i[g*ADDR_W + ADDR_W - 1];
  end
endmodule

// File: rtl/seq_ctrl_decode.sv
module seq_ctrl_decode
  import seq_pkg::*;
(
  input  phase_e cur_i,
  input  logic   dst_is_mem_i,
  input  logic   jump_cond_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (cur_i)
      PH_FETCH: begin
        ctrl_o.ir_load     = 1'b1;
        ctrl_o.pc_inc      = 1'b1;
        ctrl_o.addr_pc_sel = 1'b1;
      end
      PH_MOV: begin
        ctrl_o.mem_we = dst_is_mem_i;
        ctrl_o.rf_we  = !dst_is_mem_i;
      end
      PH_ADD: begin
        ctrl_o.mem_we  = dst_is_mem_i;
        ctrl_o.rf_we   = !dst_is_mem_i;
        ctrl_o.alu_add = 1'b1;
        ctrl_o.flag_we = 1'b1;
      end
      PH_JNG:  ctrl_o.pc_load = jump_cond_i;
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPC_W+2*ADDR_W-1:0] ir_word,
  input  logic                      flag_zero,
  input  logic                      flag_sign,
  output logic [2:0]                phase,
  output logic                      ir_load,
  output logic                      pc_inc,
  output logic                      pc_load,
  output logic [ADDR_W-1:0]         pc_target,
  output logic                      addr_pc_sel,
  output logic [ADDR_W-1:0]         dst_addr,
  output logic [ADDR_W-1:0]         src_addr,
  output logic                      dst_is_mem,
  output logic                      src_is_mem,
  output logic                      rf_we,
  output logic                      mem_we,
  output logic                      alu_op,
  output logic                      flag_we
);
  localparam int WORD_W = OPC_W + 2*ADDR_W;
  localparam int N_OPND = 2;

  opc_e                      opcode;
  phase_e                    cur, nxt;
  ctrl_t                     ctrl;
  logic [N_OPND*ADDR_W-1:0]  opnd_addr;
  logic [N_OPND-1:0]         opnd_mem;

  assign opcode = opc_e'(ir_word[WORD_W-1 -: OPC_W]);

  seq_state_reg u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt_i (nxt),
    .cur_o (cur)
  );

  seq_next_state u_next (
    .cur_i    (cur),
    .opcode_i (opcode),
    .nxt_o    (nxt)
  );

  seq_operand_split #(.ADDR_W(ADDR_W), .N_OPND(N_OPND)) u_opnd (
    .field_i  (ir_word[N_OPND*ADDR_W-1:0]),
    .addr_o   (opnd_addr),
    .is_mem_o (opnd_mem)
  );

  seq_ctrl_decode u_dec (
    .cur_i        (cur),
    .dst_is_mem_i (opnd_mem[1]),
    .jump_cond_i  (flag_sign | flag_zero),
    .ctrl_o       (ctrl)
  );

  assign phase       = cur;
  assign ir_load     = ctrl.ir_load;
  assign pc_inc      = ctrl.pc_inc;
  assign pc_load     = ctrl.pc_load;
  assign addr_pc_sel = ctrl.addr_pc_sel;
  assign rf_we       = ctrl.rf_we;
  assign mem_we      = ctrl.mem_we;
  assign alu_op      = ctrl.alu_add;
  assign flag_we     = ctrl.flag_we;
  assign dst_addr    = opnd_addr[ADDR_W +: ADDR_W];
  assign src_addr    = opnd_addr[0 +: ADDR_W];
  assign dst_is_mem  = opnd_mem[1];
  assign src_is_mem  = opnd_mem[0];
  assign pc_target   = opnd_addr[0 +: ADDR_W];
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] opc_i,
  input logic [2:0] phase,
  input logic       ir_load,
  input logic       pc_inc,
  input logic       pc_load,
  input logic       rf_we,
  input logic       mem_we,
  input logic       alu_op,
  input logic       flag_we,
  input logic       dst_is_mem
);
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |=> (phase == 3'd1));

  p_fetch_loads_ir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> (ir_load && pc_inc));

  p_exec_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 3'd2) |=> (phase == 3'd0));

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |-> !(rf_we || mem_we || flag_we || pc_load || pc_inc || ir_load));

  p_nop_skips_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && opc_i == 2'b00) |=> (phase == 3'd0));

  p_move_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |-> (mem_we == dst_is_mem && rf_we == !dst_is_mem && !flag_we && !alu_op));

  p_add_flags_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (phase == 3'd3 && alu_op && (rf_we || mem_we)));

  p_jump_only_in_jng_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (phase == 3'd4 && !rf_we && !mem_we));

  p_exclusive_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we) && !(pc_inc && pc_load));
endmodule

bind mc_sequencer seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opc_i      (opcode),
  .phase      (phase),
  .ir_load    (ir_load),
  .pc_inc     (pc_inc),
  .pc_load    (pc_load),
  .rf_we      (rf_we),
  .mem_we     (mem_we),
  .alu_op     (alu_op),
  .flag_we    (flag_we),
  .dst_is_mem (dst_is_mem)
);

// File: tb/test_mc_sequencer.sv
`timescale 1ns/1ps
module test_mc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ir_word;
  logic        flag_zero, flag_sign;
  logic [2:0]  phase;
  logic        ir_load, pc_inc, pc_load, addr_pc_sel;
  logic [6:0]  pc_target, dst_addr, src_addr;
  logic        dst_is_mem, src_is_mem, rf_we, mem_we, alu_op, flag_we;

  int n_chk = 0;
  int n_err = 0;
  bit wd    = 1'b0;

  always #10 clk = ~clk;

  mc_sequencer i_mc_sequencer (
    .clk(clk), .rst_n(rst_n), .ir_word(ir_word),
    .flag_zero(flag_zero), .flag_sign(flag_sign),
    .phase(phase), .ir_load(ir_load), .pc_inc(pc_inc), .pc_load(pc_load),
    .pc_target(pc_target), .addr_pc_sel(addr_pc_sel),
    .dst_addr(dst_addr), .src_addr(src_addr),
    .dst_is_mem(dst_is_mem), .src_is_mem(src_is_mem),
    .rf_we(rf_we), .mem_we(mem_we), .alu_op(alu_op), .flag_we(flag_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // strobe vector order: ir_load pc_inc pc_load addr_pc_sel rf_we mem_we alu_op flag_we
  function automatic logic [7:0] strobes();
    return {ir_load, pc_inc, pc_load, addr_pc_sel, rf_we, mem_we, alu_op, flag_we};
  endfunction

  task automatic run_instr(input int op, input bit dmem, input bit smem, input int fl);
    logic [6:0] d, s;
    logic [7:0] exp_s;
    bit cond;
    d = {dmem, 6'(op*7 + fl + 1)};
    s = {smem, 6'(13 + op*3 + fl)};
    cond = fl[0] | fl[1];
    ir_word   = {2'(op), d, s};
    flag_sign = fl[1];
    flag_zero = fl[0];
    #1;
    chk("R2 fetch phase", 32'(phase), 32'd0);
    chk("R2 fetch strobes", 32'(strobes()), 32'b1101_0000);
    chk("R5 dst field", 32'(dst_addr), 32'(d));
    chk("R5 src field", 32'(src_addr), 32'(s));
    @(negedge clk);
    chk("R3 decode phase", 32'(phase), 32'd1);
    chk("R3 decode strobes", 32'(strobes()), 32'd0);
    @(negedge clk);
    if (op == 0) begin
      chk("R9 nop back to fetch", 32'(phase), 32'd0);
      return;
    end
    chk("R5 kinds", 32'({dst_is_mem, src_is_mem}), 32'({dmem, smem}));
    case (op)
      1: begin
        exp_s = {4'b0000, !dmem, dmem, 2'b00};
        chk("R3 move phase", 32'(phase), 32'd2);
        chk("R6 move strobes", 32'(strobes()), 32'(exp_s));
      end
      3: begin
        exp_s = {4'b0000, !dmem, dmem, 2'b11};
        chk("R3 add phase", 32'(phase), 32'd3);
        chk("R7 add write with flags", 32'(strobes()), 32'(exp_s));
      end
      default: begin
        exp_s = {2'b00, cond, 5'b00000};
        chk("R3 jump phase", 32'(phase), 32'd4);
        chk("R8 jump strobes", 32'(strobes()), 32'(exp_s));
        chk("R5 jump target", 32'(pc_target), 32'(s));
      end
    endcase
    chk("R10 exclusive", 32'({rf_we & mem_we, pc_inc & pc_load}), 32'd0);
    @(negedge clk);
    chk("R4 back to fetch", 32'(phase), 32'd0);
  endtask

  task automatic run_all();
    rst_n = 1'b0; ir_word = '0; flag_zero = 1'b0; flag_sign = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", 32'(phase), 32'd0);
    chk("R1 reset strobes", 32'({rf_we, mem_we, flag_we, pc_load}), 32'd0);
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int dm = 0; dm < 2; dm++)
        for (int sm = 0; sm < 2; sm++)
          for (int fl = 0; fl < 4; fl++)
            run_instr(op, dm[0], sm[0], fl);
    // reset taken in the middle of an add
    ir_word = {2'b11, 7'b0000001, 7'b1000010};
    @(negedge clk);
    chk("R3 decode before reset", 32'(phase), 32'd1);
    @(negedge clk);
    chk("R7 add before reset", 32'(phase), 32'd3);
    #5 rst_n = 1'b0;
    #1;
    chk("R1 async reset phase", 32'(phase), 32'd0);
    chk("R1 async reset strobes", 32'({rf_we, mem_we, flag_we, pc_load}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 decode after release", 32'(phase), 32'd1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (5000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule